// File: doc/BRIEF.md
# Scroll and Video Address Register

This block holds the scroll state of a tile-based video generator: a 15-bit current video address, a 15-bit staged address, a 3-bit fine horizontal scroll and a shared first/second write toggle. A host processor reaches it through a small register interface. It can write a control byte, write a scroll byte twice, write an address byte twice, read status (which only resets the toggle) and access the data port (which steps the address). The current address is laid out as coarse X in bits 4:0, coarse Y in bits 9:5, the horizontal and vertical page selects in bits 10 and 11, and fine Y in bits 14:12.

While the picture is being built, a dot counter and line flags from the timing generator drive the address. It steps horizontally once per tile and vertically once per line, and it reloads from the staged address at fixed dots. The block derives the tile-name and attribute fetch addresses from the current address. The fetch engine uses these addresses. Rendering counts as active when `render_en` is high on a visible line or on the pre-render line.

Top module: `scroll_addr_reg`

## Requirements
- R1: A control write (`reg_sel`=0) puts `reg_wdata[1:0]` into staged bits 11:10 and latches `reg_wdata[2]` as the vertical-step bit.
- R2: With the toggle clear, a scroll write (`reg_sel`=1) sets fine X to `reg_wdata[2:0]` and staged bits 4:0 to `reg_wdata[7:3]`. With the toggle set, it sets staged bits 14:12 to `reg_wdata[2:0]` and staged bits 9:5 to `reg_wdata[7:3]`.
- R3: With the toggle clear, an address write (`reg_sel`=2) sets staged bits 13:8 to `reg_wdata[5:0]` and clears staged bit 14. With the toggle set, it sets staged bits 7:0 to `reg_wdata`. The resulting staged value then appears on `vaddr` two clock edges after the staged register is updated, which is the third edge after the strobe.
- R4: Each scroll or address write inverts the toggle. A status read clears it. When a status read and a write fall in the same cycle, the write uses the old toggle and the toggle ends up clear.
- R5: A coarse-X step adds 1 to bits 4:0. From 31 it wraps to 0 and inverts bit 10.
- R6: A Y step adds 1 to bits 14:12 when they are below 7. Otherwise it clears them and advances bits 9:5: 29 goes to 0 and inverts bit 11, 31 goes to 0 without inverting, and any other value increments.
- R7: While rendering, a coarse-X step occurs at every dot that is a multiple of 8 from 8 to 256, and at dots 328 and 336. A Y step occurs at dot 256. None of these occur when rendering is not active.
- R8: While rendering, dot 257 copies the bits under mask 0x041F from the staged address. On the pre-render line, dots 280 to 304 copy the bits under mask 0x7BE0.
- R9: A data-port access outside rendering adds 1 to the address, or 32 when the vertical-step bit is set. The result is 15 bits and wraps.
- R10: A data-port access during rendering performs one coarse-X step and one Y step together.
- R11: `nt_fetch` = 0x2000 | `vaddr[11:0]`. `at_fetch` = 0x23C0 | `vaddr[11:10]`<<10 | `vaddr[9:7]`<<3 | `vaddr[4:2]`.
- R12: The address update takes priority in this order: the delayed address commit first, then a data-port access, then the dot-timed steps and copies.
- R13: Reset clears the current and staged addresses, fine X, the toggle, the vertical-step bit and any pending commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 scroll, 2 address, 3 none |
| reg_wdata | input | 8 | Register write data |
| stat_rd | input | 1 | Status read strobe (clears the toggle) |
| data_acc | input | 1 | Data-port access strobe |
| render_en | input | 1 | Background or sprite drawing enabled |
| line_visible | input | 1 | Current line is a visible line |
| line_prerender | input | 1 | Current line is the pre-render line |
| dot | input | 9 | Dot index within the line |
| vaddr | output | 15 | Current video address |
| fine_x | output | 3 | Fine horizontal scroll |
| nt_fetch | output | 14 | Tile-name fetch address |
| at_fetch | output | 14 | Attribute fetch address |

## Verification
A data-port access can land on the same dot as a timed event. The clearest case is dot 257, where an access during rendering must step the address instead of performing the horizontal copy. An access can also land on the edge where a pending address commit completes, and there the committed value must win. Both cases are set up directly, and random stimulus also creates them. A bench model applies the stated priority order every cycle and compares the result with `vaddr`.

// File: rtl/scroll_addr_pkg.sv
package scroll_addr_pkg;

    localparam int VA_W = 15;

    typedef logic [VA_W-1:0] vaddr_t;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_SCROLL = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic rendering;
        logic xinc;
        logic yinc;
        logic hcopy;
        logic vcopy;
    } dot_ev_t;

    localparam vaddr_t HCOPY_MASK = 15'h041F;
    localparam vaddr_t VCOPY_MASK = 15'h7BE0;

    function automatic vaddr_t step_coarse_x(input vaddr_t a);
        vaddr_t r;
        r = a;
        if (a[4:0] == 5'd31) begin
            r[4:0] = 5'd0;
            r[10]  = ~a[10];
        end else begin
            r[4:0] = a[4:0] + 5'd1;
        end
        return r;
    endfunction

    function automatic vaddr_t step_y(input vaddr_t a);
        vaddr_t r;
        r = a;
        if (a[14:12] != 3'd7) begin
            r[14:12] = a[14:12] + 3'd1;
        end else begin
            r[14:12] = 3'd0;
            if (a[9:5] == 5'd29) begin
                r[9:5] = 5'd0;
                r[11]  = ~a[11];
            end else if (a[9:5] == 5'd31) begin
                r[9:5] = 5'd0;
            end else begin
                r[9:5] = a[9:5] + 5'd1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/scroll_wr_regs.sv
module scroll_wr_regs
    import scroll_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    input  logic       stat_rd,
    output vaddr_t     t_q,
    output logic [2:0] fine_x_q,
    output logic       vstep_q,
    output logic       commit_load,
    output vaddr_t     commit_val
);

    typedef struct packed {
        vaddr_t     t;
        logic [2:0] fx;
        logic       tog;
        logic       vstep;
    } wr_state_t;

    wr_state_t st_d, st_q;
    reg_sel_e  sel;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        st_d        = st_q;
        commit_load = 1'b0;
        if (reg_wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    st_d.t[11:10] = reg_wdata[1:0];
                    st_d.vstep    = reg_wdata[2];
                end
                SEL_SCROLL: begin
                    if (!st_q.tog) begin
                        st_d.fx     = reg_wdata[2:0];
                        st_d.t[4:0] = reg_wdata[7:3];
                    end else begin
                        st_d.t[14:12] = reg_wdata[2:0];
                        st_d.t[9:5]   = reg_wdata[7:3];
                    end
                    st_d.tog = ~st_q.tog;
                end
                SEL_ADDR: begin
                    if (!st_q.tog) begin
                        st_d.t[13:8] = reg_wdata[5:0];
                        st_d.t[14]   = 1'b0;
                    end else begin
                        st_d.t[7:0]  = reg_wdata;
                        commit_load  = 1'b1;
                    end
                    st_d.tog = ~st_q.tog;
                end
                default: ;
            endcase
        end
        if (stat_rd) begin
            st_d.tog = 1'b0;
        end
        commit_val = st_d.t;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign t_q      = st_q.t;
    assign fine_x_q = st_q.fx;
    assign vstep_q  = st_q.vstep;

    p_ctrl_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> (t_q[11:10] == $past(reg_wdata[1:0])));

    p_fine_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && !st_q.tog) |=> (fine_x_q == $past(reg_wdata[2:0])));

    p_addr_hi_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd2 && !st_q.tog) |=> (t_q[14] == 1'b0));

    p_toggle_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !st_q.tog);

    p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == 2'd1 || reg_sel == 2'd2) && !stat_rd)
        |=> (st_q.tog != $past(st_q.tog)));

endmodule

// File: rtl/scroll_dot_events.sv
module scroll_dot_events
    import scroll_addr_pkg::*;
#(
    parameter int DOT_W     = 9,
    parameter int TILE_DOTS = 8,
    parameter int DOT_YINC  = 256,
    parameter int DOT_HCOPY = 257,
    parameter int DOT_VC_LO = 280,
    parameter int DOT_VC_HI = 304,
    parameter int DOT_PF_A  = 328,
    parameter int DOT_PF_B  = 336
) (
    input  logic             render_en,
    input  logic             line_visible,
    input  logic             line_prerender,
    input  logic [DOT_W-1:0] dot,
    output dot_ev_t          ev
);

    localparam int TILE_LSB = $clog2(TILE_DOTS);
    localparam logic [DOT_W-1:0] D_TILE  = DOT_W'(TILE_DOTS);
    localparam logic [DOT_W-1:0] D_YINC  = DOT_W'(DOT_YINC);
    localparam logic [DOT_W-1:0] D_HCOPY = DOT_W'(DOT_HCOPY);
    localparam logic [DOT_W-1:0] D_VC_LO = DOT_W'(DOT_VC_LO);
    localparam logic [DOT_W-1:0] D_VC_HI = DOT_W'(DOT_VC_HI);
    localparam logic [DOT_W-1:0] D_PF_A  = DOT_W'(DOT_PF_A);
    localparam logic [DOT_W-1:0] D_PF_B  = DOT_W'(DOT_PF_B);

    logic active;
    logic tile_edge;

    always_comb begin
        active    = render_en && (line_visible || line_prerender);
        tile_edge = (dot[TILE_LSB-1:0] == '0) && (dot >= D_TILE) && (dot <= D_YINC);
        ev.rendering = active;
        ev.xinc      = active && (tile_edge || dot == D_PF_A || dot == D_PF_B);
        ev.yinc      = active && (dot == D_YINC);
        ev.hcopy     = active && (dot == D_HCOPY);
        ev.vcopy     = active && line_prerender && (dot >= D_VC_LO) && (dot <= D_VC_HI);
    end

endmodule

// File: rtl/scroll_v_path.sv
module scroll_v_path
    import scroll_addr_pkg::*;
#(
    parameter int COMMIT_DLY = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  vaddr_t  t_q,
    input  logic    vstep_q,
    input  logic    commit_load,
    input  vaddr_t  commit_val,
    input  logic    data_acc,
    input  dot_ev_t ev,
    output vaddr_t  v_q
);

    localparam int CNT_W = $clog2(COMMIT_DLY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_DLY);
    localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(1);

    typedef struct packed {
        vaddr_t           v;
        vaddr_t           cval;
        logic [CNT_W-1:0] cnt;
    } vp_state_t;

    vp_state_t st_d, st_q;
    vaddr_t    timed;
    logic      fire;

    always_comb begin
        st_d  = st_q;
        fire  = (st_q.cnt == CNT_FIRE);
        timed = st_q.v;
        if (ev.xinc)  timed = step_coarse_x(timed);
        if (ev.yinc)  timed = step_y(timed);
        if (ev.hcopy) timed = (timed & ~HCOPY_MASK) | (t_q & HCOPY_MASK);
        if (ev.vcopy) timed = (timed & ~VCOPY_MASK) | (t_q & VCOPY_MASK);

        if (fire) begin
            st_d.v = st_q.cval;
        end else if (data_acc) begin
            st_d.v = ev.rendering ? step_y(step_coarse_x(st_q.v))
                                  : st_q.v + (vstep_q ? 15'd32 : 15'd1);
        end else begin
            st_d.v = timed;
        end

        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (commit_load) begin
            st_d.cnt  = CNT_LOAD;
            st_d.cval = commit_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign v_q = st_q.v;

    p_commit_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_FIRE) |=> (v_q == $past(st_q.cval)));

    p_hcopy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.hcopy && !data_acc && st_q.cnt != CNT_FIRE)
        |=> ((v_q & HCOPY_MASK) == ($past(t_q) & HCOPY_MASK)));

    p_data_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !ev.rendering && st_q.cnt != CNT_FIRE)
        |=> (v_q == $past(v_q) + ($past(vstep_q) ? 15'd32 : 15'd1)));

    p_fine_y_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.yinc && !data_acc && st_q.cnt != CNT_FIRE && v_q[14:12] != 3'd7)
        |=> (v_q[14:12] == $past(v_q[14:12]) + 3'd1));

    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_acc && st_q.cnt != CNT_FIRE && !ev.xinc && !ev.yinc && !ev.hcopy && !ev.vcopy)
        |=> $stable(v_q));

endmodule

// File: rtl/scroll_fetch_addr.sv
module scroll_fetch_addr
    import scroll_addr_pkg::*;
(
    input  vaddr_t      v_q,
    output logic [13:0] nt_fetch,
    output logic [13:0] at_fetch
);

    always_comb begin
        nt_fetch = {2'b10, v_q[11:0]};
        at_fetch = {2'b10, v_q[11:10], 4'b1111, v_q[9:7], v_q[4:2]};
    end

endmodule

// File: rtl/scroll_addr_reg.sv
module scroll_addr_reg
    import scroll_addr_pkg::*;
#(
    parameter int DOT_W      = 9,
    parameter int COMMIT_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    input  logic             stat_rd,
    input  logic             data_acc,
    input  logic             render_en,
    input  logic             line_visible,
    input  logic             line_prerender,
    input  logic [DOT_W-1:0] dot,
    output logic [14:0]      vaddr,
    output logic [2:0]       fine_x,
    output logic [13:0]      nt_fetch,
    output logic [13:0]      at_fetch
);

    vaddr_t  t_q;
    vaddr_t  v_q;
    vaddr_t  commit_val;
    logic    vstep_q;
    logic    commit_load;
    dot_ev_t ev;

    scroll_wr_regs u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .stat_rd     (stat_rd),
        .t_q         (t_q),
        .fine_x_q    (fine_x),
        .vstep_q     (vstep_q),
        .commit_load (commit_load),
        .commit_val  (commit_val)
    );

    scroll_dot_events #(.DOT_W(DOT_W)) u_ev (
        .render_en      (render_en),
        .line_visible   (line_visible),
        .line_prerender (line_prerender),
        .dot            (dot),
        .ev             (ev)
    );

    scroll_v_path #(.COMMIT_DLY(COMMIT_DLY)) u_v (
        .clk         (clk),
        .rst_n       (rst_n),
        .t_q         (t_q),
        .vstep_q     (vstep_q),
        .commit_load (commit_load),
        .commit_val  (commit_val),
        .data_acc    (data_acc),
        .ev          (ev),
        .v_q         (v_q)
    );

    scroll_fetch_addr u_fa (
        .v_q      (v_q),
        .nt_fetch (nt_fetch),
        .at_fetch (at_fetch)
    );

    assign vaddr = v_q;

endmodule

// File: tb/sim_scroll_addr_reg.sv
module sim_scroll_addr_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [7:0]  reg_wdata = 8'd0;
    logic        stat_rd = 1'b0;
    logic        data_acc = 1'b0;
    logic        render_en = 1'b0;
    logic        line_visible = 1'b0;
    logic        line_prerender = 1'b0;
    logic [8:0]  dot = 9'd0;
    logic [14:0] vaddr;
    logic [2:0]  fine_x;
    logic [13:0] nt_fetch;
    logic [13:0] at_fetch;

    int n_tests = 0;
    int n_fail = 0;
    string cur_tag = "R13";

    // bench model
    logic [14:0] mv, mt, mcval;
    logic [2:0]  mfx;
    logic        mtog, mvs;
    int          mpend;

    always #10 clk = ~clk;

    scroll_addr_reg u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_rd(stat_rd), .data_acc(data_acc),
        .render_en(render_en), .line_visible(line_visible),
        .line_prerender(line_prerender), .dot(dot), .vaddr(vaddr),
        .fine_x(fine_x), .nt_fetch(nt_fetch), .at_fetch(at_fetch)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] m_xstep(input logic [14:0] a);
        int cx;
        cx = int'(a & 15'h001F);
        if (cx == 31) return (a & ~15'h001F) ^ 15'h0400;
        return a + 15'd1;
    endfunction

    function automatic logic [14:0] m_ystep(input logic [14:0] a);
        int fy, cy;
        logic [14:0] r;
        fy = int'(a >> 12) & 7;
        if (fy < 7) return a + 15'h1000;
        r  = a & ~15'h7000;
        cy = int'(r >> 5) & 31;
        if (cy == 29) begin
            cy = 0;
            r  = r ^ 15'h0800;
        end else if (cy == 31) begin
            cy = 0;
        end else begin
            cy = cy + 1;
        end
        return (r & ~15'h03E0) | 15'(cy << 5);
    endfunction

    task automatic model_reset();
        mv = '0; mt = '0; mcval = '0; mfx = '0; mtog = 1'b0; mvs = 1'b0; mpend = 0;
    endtask

    task automatic model_step();
        logic        rend;
        logic [14:0] nv, nt;
        int          d;
        d    = int'(dot);
        rend = render_en && (line_visible || line_prerender);
        nv   = mv;
        if (rend) begin
            if ((d % 8 == 0 && d >= 8 && d <= 256) || d == 328 || d == 336) nv = m_xstep(nv);
            if (d == 256) nv = m_ystep(nv);
            if (d == 257) nv = (nv & ~15'h041F) | (mt & 15'h041F);
            if (line_prerender && d >= 280 && d <= 304) nv = (nv & ~15'h7BE0) | (mt & 15'h7BE0);
        end
        if (data_acc) nv = rend ? m_ystep(m_xstep(mv)) : mv + (mvs ? 15'd32 : 15'd1);
        if (mpend == 1) nv = mcval;
        if (mpend > 0) mpend--;
        nt = mt;
        if (reg_wr) begin
            if (reg_sel == 2'd0) begin
                nt[11:10] = reg_wdata[1:0];
                mvs = reg_wdata[2];
            end else if (reg_sel == 2'd1) begin
                if (!mtog) begin
                    mfx = reg_wdata[2:0];
                    nt[4:0] = reg_wdata[7:3];
                end else begin
                    nt[14:12] = reg_wdata[2:0];
                    nt[9:5] = reg_wdata[7:3];
                end
                mtog = ~mtog;
            end else if (reg_sel == 2'd2) begin
                if (!mtog) begin
                    nt[13:8] = reg_wdata[5:0];
                    nt[14] = 1'b0;
                end else begin
                    nt[7:0] = reg_wdata;
                    mpend = 2;
                    mcval = nt;
                end
                mtog = ~mtog;
            end
        end
        if (stat_rd) mtog = 1'b0;
        mt = nt;
        mv = nv;
    endtask

    task automatic compare_all();
        logic [13:0] at_exp;
        at_exp = 14'h23C0 | 14'(mv & 15'h0C00) | 14'((mv >> 4) & 15'h0038) | 14'((mv >> 2) & 15'h0007);
        chk(cur_tag, 32'(vaddr), 32'(mv));
        chk("R2 fine_x", 32'(fine_x), 32'(mfx));
        chk("R11 nt", 32'(nt_fetch), 32'(14'h2000 | 14'(mv & 15'h0FFF)));
        chk("R11 at", 32'(at_fetch), 32'(at_exp));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_sel = 2'd3; stat_rd = 1'b0; data_acc = 1'b0;
        render_en = 1'b0; line_visible = 1'b0; line_prerender = 1'b0; dot = 9'd0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic render_tick(input logic pre, input int d, input logic acc);
        render_en = 1'b1; line_visible = ~pre; line_prerender = pre;
        dot = 9'(d); data_acc = acc;
        tick();
        idle_inputs();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R13 reset v", 32'(vaddr), 32'h0);
        chk("R13 reset fx", 32'(fine_x), 32'h0);
        chk("R13 reset nt", 32'(nt_fetch), 32'h2000);
        chk("R13 reset at", 32'(at_fetch), 32'h23C0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        cur_tag = "R3";
        wr(2'd2, 8'hFF);
        wr(2'd2, 8'h12);
        tick();
        chk("R3 before commit", 32'(vaddr), 32'h0);
        tick();
        chk("R3 commit", 32'(vaddr), 32'h3F12);

        cur_tag = "R4";
        wr(2'd1, 8'h7D);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        wr(2'd1, 8'h0B);
        chk("R4 toggle cleared", 32'(fine_x), 32'h3);
        stat_rd = 1'b1; reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h30;
        tick();
        idle_inputs();
        wr(2'd1, 8'h05);
        chk("R4 read+write clears", 32'(fine_x), 32'h5);
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;

        cur_tag = "R9";
        wr(2'd2, 8'h7F);
        wr(2'd2, 8'hFF);
        tick(); tick();
        chk("R3 commit 3FFF", 32'(vaddr), 32'h3FFF);
        data_acc = 1'b1; tick(); data_acc = 1'b0;
        chk("R9 +1", 32'(vaddr), 32'h4000);
        wr(2'd0, 8'h04);
        data_acc = 1'b1; tick(); data_acc = 1'b0;
        chk("R9 +32", 32'(vaddr), 32'h4020);
        wr(2'd0, 8'h00);

        cur_tag = "R5";
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h1F);
        tick(); tick();
        line_visible = 1'b1; dot = 9'd8; tick(); idle_inputs();
        chk("R7 no step when off", 32'(vaddr), 32'h001F);
        render_tick(1'b0, 8, 1'b0);
        chk("R5 wrap flips page", 32'(vaddr), 32'h0400);

        cur_tag = "R6";
        wr(2'd1, 8'h00);
        wr(2'd1, 8'hEF);
        render_tick(1'b1, 280, 1'b0);
        chk("R8 vcopy", 32'(vaddr), 32'h77A0);
        render_tick(1'b0, 256, 1'b0);
        chk("R6 coarse 29", 32'(vaddr), 32'h0C01);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'hFF);
        render_tick(1'b1, 290, 1'b0);
        chk("R8 vcopy 2", 32'(vaddr), 32'h77E1);
        render_tick(1'b0, 256, 1'b0);
        chk("R6 coarse 31", 32'(vaddr), 32'h0402);

        cur_tag = "R8";
        render_tick(1'b0, 257, 1'b0);
        chk("R8 hcopy", 32'(vaddr), 32'h0000);

        cur_tag = "R10";
        render_tick(1'b0, 100, 1'b1);
        chk("R10 access in render", 32'(vaddr), 32'h1001);

        cur_tag = "R7";
        render_tick(1'b0, 328, 1'b0);
        chk("R7 dot 328", 32'(vaddr), 32'h1002);

        cur_tag = "R12";
        render_tick(1'b0, 257, 1'b1);
        chk("R12 access beats hcopy", 32'(vaddr), 32'h2003);
        wr(2'd2, 8'h01);
        wr(2'd2, 8'h23);
        tick();
        data_acc = 1'b1; tick(); data_acc = 1'b0;
        chk("R12 commit beats access", 32'(vaddr), 32'h0123);

        cur_tag = "R1";
        wr(2'd0, 8'h03);
        render_tick(1'b1, 280, 1'b0);
        render_tick(1'b0, 257, 1'b0);
        chk("R1 page bits", 32'(vaddr[11:10]), 32'h3);
        chk("R11 nt explicit", 32'(nt_fetch), 32'h2D23);
        chk("R11 at explicit", 32'(at_fetch), 32'h2FD0);
        wr(2'd0, 8'h00);

        cur_tag = "R13";
        wr(2'd2, 8'h15);
        wr(2'd2, 8'h55);
        do_reset();
        tick(); tick(); tick();
        chk("R13 no pending commit", 32'(vaddr), 32'h0);

        cur_tag = "R12 random";
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            reg_wr    = ($urandom % 6) == 0;
            reg_sel   = 2'($urandom % 3);
            reg_wdata = 8'($urandom);
            stat_rd   = ($urandom % 10) == 0;
            data_acc  = ($urandom % 8) == 0;
            render_en = ($urandom % 4) != 0;
            line_prerender = ($urandom % 3) == 0;
            line_visible   = !line_prerender && (($urandom % 5) != 0);
            case ($urandom % 6)
                0: dot = 9'd256;
                1: dot = 9'd257;
                2: dot = 9'(280 + ($urandom % 25));
                3: dot = 9'(($urandom % 33) * 8);
                4: dot = (($urandom % 2) == 0) ? 9'd328 : 9'd336;
                default: dot = 9'($urandom % 341);
            endcase
            tick();
        end
        idle_inputs();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule